// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects interrupt requests from a parameterised set of sources and routes them to a small number of hart contexts. Each source has its own priority register. Each context has its own enable bit vector, its own threshold and a claim/complete register. A context's request line rises when at least one enabled, pending source has a priority strictly above that context's threshold.

Software takes an interrupt by reading the claim register. The read returns the ID of the best qualifying source and clears that source's pending state in the same cycle. The source stays blocked until its ID is written back to the same register. Each source has a gateway, fixed by a parameter, that is either level-high or rising-edge sensitive. Source ID 0 is reserved and never requests.

Register access uses a plain 32-bit word bus. Reads are combinational in the request cycle, and writes take effect at the clock edge that ends the request.

Top module: `irq_router`

## Requirements
- R1: Source N's priority is at byte address N*4 and holds bits [2:0]. Bits [31:3] read as zero. Source 0's word always reads zero and ignores writes.
- R2: Context c's enable word k is at 0x2000 + c*0x80 + k*4. Source N uses bit N%32 of word N/32. Bit 0 of word 0, which belongs to source 0, always reads zero.
- R3: Context c's threshold is at 0x200000 + c*0x1000 and its claim/complete register is at the same base + 4. Contexts are fully independent of one another.
- R4: irq_o[c] is high exactly when some pending source enabled for c has a priority strictly greater than c's threshold. Priority 0 never interrupts. A threshold of 7 masks every source.
- R5: A claim read returns the qualifying source with the highest priority, and the lowest ID among equal priorities. When no source qualifies, it returns 0 and changes nothing.
- R6: A claim read that returns a nonzero ID clears that source's pending state. The source requests no more until it has been completed.
- R7: A write of an ID to a context's claim/complete register completes that source only if the source is enabled for that context. Otherwise the write is ignored.
- R8: A level source re-pends after completion if its input is still high. It does not re-pend if its input is low.
- R9: A rising edge on an edge source while it is in flight is remembered and raises pending at completion. Several edges while the source is already pending count as one.
- R10: Reads of unimplemented offsets, including absent contexts and words past the last enable word, return zero. Writes to those offsets change nothing.
- R11: After reset, all priorities, enables, thresholds and pending state are zero, and every irq_o bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Raw interrupt inputs, one per source ID; bit 0 has no effect |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | NCTX | Interrupt request, one per context |

## Verification
The assertions assume that the address is word aligned and that a request is held for exactly one cycle. They also assume that the claim/complete register is only ever read for a real claim, because any such read with irq_o high is taken to return a live source ID. The bench drives the bus only through single-cycle read and write tasks with aligned addresses. It drives source inputs at the falling edge, so the gateways sample stable values. Random arbitration rounds complete every source they claim before the next round, so no round starts with a source still in flight.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTL_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;
  localparam logic [31:0] THR_OFF    = 32'h0000_0000;
  localparam logic [31:0] CLM_OFF    = 32'h0000_0004;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway import irq_router_pkg::*; #(
  parameter trig_e MODE = TRIG_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o
);
  logic pend_q, busy_q, held_q, prev_q;
  logic pend_d, busy_d, held_d;
  logic rise;

  assign rise = req_i & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    held_d = held_q;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else if (done_i && busy_q) begin
      busy_d = 1'b0;
      if (held_q) pend_d = 1'b1;
      held_d = 1'b0;
    end
    if (MODE == TRIG_EDGE) begin
      // an edge arriving while in flight is parked, not dropped
      if (rise) begin
        if (busy_d) held_d = 1'b1;
        else        pend_d = 1'b1;
      end
    end else begin
      held_d = 1'b0;
      if (req_i && !busy_q && !claim_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      held_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      held_q <= held_d;
      prev_q <= req_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [ID_W-1:0]             id_o,
  output logic                        req_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  // seeding with the threshold makes "strictly above" fall out of the compare;
  // scanning upward with a strict compare keeps the lowest ID on ties
  always_comb begin
    best_p  = thr_i;
    best_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (prio_i[i] > best_p)) begin
        best_p  = prio_i[i];
        best_id = ID_W'(i);
      end
    end
  end

  assign id_o  = best_id;
  assign req_o = (best_id != '0);
endmodule

// File: rtl/irq_router.sv
module irq_router import irq_router_pkg::*; #(
  parameter int              NSRC      = 32,
  parameter int              NCTX      = 2,
  parameter int              PRIO_W    = 3,
  parameter int              ADDR_W    = 26,
  parameter logic [NSRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W  = $clog2(NSRC);
  localparam int NWORD = (NSRC + 31) / 32;
  localparam int ENW   = NWORD * 32;

  logic rst_q_n;
  irq_rst_sync u_rst (.clk_i(clk_i), .arst_ni(rst_ni), .rst_no(rst_q_n));

  // register state
  logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NCTX-1:0][ENW-1:0]    en_q, en_d;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q, thr_d;

  // address decode
  logic [31:0] a, en_off, ctl_off, en_w;
  logic rd_en, wr_en, prio_hit, en_hit, ctl_hit;
  logic [NSRC-1:0] prio_sel;
  logic [NCTX-1:0] en_sel, thr_sel, clm_sel;

  assign a        = 32'(bus_addr_i);
  assign rd_en    = bus_req_i & ~bus_we_i;
  assign wr_en    = bus_req_i &  bus_we_i;
  assign prio_hit = a < 32'(NSRC * 4);
  assign en_off   = a - EN_BASE;
  assign en_w     = (en_off % EN_STRIDE) / 32'd4;
  assign en_hit   = (a >= EN_BASE) && (a < EN_BASE + 32'(NCTX) * EN_STRIDE) &&
                    (en_w < 32'(NWORD));
  assign ctl_off  = a - CTL_BASE;
  assign ctl_hit  = (a >= CTL_BASE) && (a < CTL_BASE + 32'(NCTX) * CTL_STRIDE);

  for (genvar i = 0; i < NSRC; i++) begin : g_psel
    assign prio_sel[i] = prio_hit && (a[31:2] == 30'(i));
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_csel
    assign en_sel[c]  = en_hit  && (en_off / EN_STRIDE == 32'(c));
    assign thr_sel[c] = ctl_hit && (ctl_off / CTL_STRIDE == 32'(c)) &&
                        (ctl_off % CTL_STRIDE == THR_OFF);
    assign clm_sel[c] = ctl_hit && (ctl_off / CTL_STRIDE == 32'(c)) &&
                        (ctl_off % CTL_STRIDE == CLM_OFF);
  end

  // gateways and arbitration
  logic [NSRC-1:0] pend, claim, done;
  logic [NCTX-1:0][ID_W-1:0] win_id;
  logic [NCTX-1:0]           win_req;

  for (genvar i = 0; i < NSRC; i++) begin : g_gw
    irq_gateway #(.MODE(trig_e'(EDGE_MASK[i]))) u_gw (
      .clk_i  (clk_i),
      .rst_ni (rst_q_n),
      .req_i  (src_i[i]),
      .claim_i(claim[i]),
      .done_i (done[i]),
      .pend_o (pend[i])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_arb
    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand_i(pend & en_q[c][NSRC-1:0]),
      .prio_i(prio_q),
      .thr_i (thr_q[c]),
      .id_o  (win_id[c]),
      .req_o (win_req[c])
    );
  end

  assign irq_o = win_req;

  // claim and completion strobes
  always_comb begin
    claim = '0;
    done  = '0;
    for (int c = 0; c < NCTX; c++) begin
      for (int i = 0; i < NSRC; i++) begin
        if (rd_en && clm_sel[c] && win_req[c] && (win_id[c] == ID_W'(i)))
          claim[i] = 1'b1;
        if (wr_en && clm_sel[c] && en_q[c][i] && (bus_wdata_i == 32'(i)))
          done[i] = 1'b1;
      end
    end
  end

  // register next state
  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    thr_d  = thr_q;
    for (int i = 0; i < NSRC; i++)
      if (prio_sel[i] && (i != 0)) prio_d[i] = bus_wdata_i[PRIO_W-1:0];
    for (int c = 0; c < NCTX; c++) begin
      if (thr_sel[c]) thr_d[c] = bus_wdata_i[PRIO_W-1:0];
      if (en_sel[c]) begin
        for (int w = 0; w < NWORD; w++) begin
          if (en_w == 32'(w)) begin
            for (int b = 0; b < 32; b++)
              if ((w * 32 + b >= 1) && (w * 32 + b < NSRC))
                en_d[c][w*32+b] = bus_wdata_i[b];
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      for (int i = 0; i < NSRC; i++)
        if (prio_sel[i]) bus_rdata_o = 32'(prio_q[i]);
      for (int c = 0; c < NCTX; c++) begin
        if (en_sel[c]) begin
          for (int w = 0; w < NWORD; w++)
            if (en_w == 32'(w)) bus_rdata_o = en_q[c][w*32 +: 32];
        end
        if (thr_sel[c]) bus_rdata_o = 32'(thr_q[c]);
        if (clm_sel[c]) bus_rdata_o = 32'(win_id[c]);
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk import irq_router_pkg::*; #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [NCTX-1:0]   irq_o
);
  logic [31:0] a;
  logic        rd;
  assign a  = 32'(bus_addr_i);
  assign rd = bus_req_i && !bus_we_i;

  p_prio_narrow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a < 32'(NSRC * 4)) |-> (bus_rdata_o[31:PRIO_W] == '0));

  p_src0_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a[31:2] == 30'd0) |-> (bus_rdata_o == 32'd0));

  p_gap_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a >= 32'(NSRC * 4) && a < EN_BASE) |-> (bus_rdata_o == 32'd0));

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    p_claim_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && a == CTL_BASE + 32'(c) * CTL_STRIDE + CLM_OFF && !irq_o[c])
        |-> (bus_rdata_o == 32'd0));

    p_claim_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && a == CTL_BASE + 32'(c) * CTL_STRIDE + CLM_OFF && irq_o[c])
        |-> (bus_rdata_o != 32'd0 && bus_rdata_o < 32'(NSRC)));
  end
endmodule

bind irq_router irq_router_chk #(
  .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  localparam int NSRC = 32;
  localparam int NCTX = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC-1:0]   src;
  logic              req, we;
  logic [25:0]       addr;
  logic [31:0]       wdata, rdata;
  logic [NCTX-1:0]   irq;

  int n_chk = 0;
  int n_bad = 0;
  bit fin   = 1'b0;
  int p [16];

  always #2.5 clk = ~clk;

  irq_router #(.NSRC(NSRC), .NCTX(NCTX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] pa(int n); return 32'(n * 4); endfunction
  function automatic logic [31:0] ea(int c); return 32'h2000 + 32'(c * 32'h80); endfunction
  function automatic logic [31:0] ta(int c); return 32'h20_0000 + 32'(c * 32'h1000); endfunction
  function automatic logic [31:0] ca(int c); return ta(c) + 32'd4; endfunction

  // expected claim result for sources 1..15 from bench-held priorities
  function automatic int best_id(logic [31:0] mask, int thr);
    int bid = 0;
    int bp  = thr;
    for (int j = 1; j < 16; j++)
      if (mask[j] && p[j] > bp) begin bid = j; bp = p[j]; end
    return bid;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a[25:0]; wdata = d;
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a[25:0];
    #1 d = rdata;
    @(posedge clk); #1; req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(int i, logic v);
    @(negedge clk); src[i] = v;
  endtask

  task automatic pulse(int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] mask;
    int thr, e;
    rst_n = 1'b0; src = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R11 reset state
    rd(pa(5), d);   chk("R11 prio", d, 0);
    rd(ea(0), d);   chk("R11 enable", d, 0);
    rd(ta(1), d);   chk("R11 threshold", d, 0);
    chk("R11 irq", 32'(irq), 0);
    rd(ca(0), d);   chk("R11 claim", d, 0);

    // R1 priority width, source 0
    wr(pa(5), 32'hFFFF_FFFF); rd(pa(5), d); chk("R1 prio mask", d, 7);
    wr(pa(0), 7);             rd(pa(0), d); chk("R1 src0 prio", d, 0);
    wr(pa(5), 0);

    // R2 enable layout
    wr(ea(0), 32'hFFFF_FFFF); rd(ea(0), d); chk("R2 enable bit0", d, 32'hFFFF_FFFE);
    wr(ea(0), 0);
    wr(ea(1), 32'h0000_00A4); rd(ea(1), d); chk("R2 enable ctx1", d, 32'h0000_00A4);
    rd(ea(0), d); chk("R2 ctx0 untouched", d, 0);
    wr(ea(1), 0);

    // R10 unimplemented offsets
    wr(32'h1000, 32'h1234_5678); rd(32'h1000, d); chk("R10 gap read", d, 0);
    rd(pa(5), d); chk("R10 gap write", d, 0);
    wr(ea(2), 32'hFFFF_FFFF); rd(ea(2), d); chk("R10 absent ctx enable", d, 0);
    rd(ea(0) + 4, d); chk("R10 past last word", d, 0);
    rd(ta(0) + 8, d); chk("R10 ctl hole", d, 0);
    wr(ta(2), 5); rd(ta(2), d); chk("R10 absent ctx thr", d, 0);
    rd(ta(0), d); chk("R10 thr0 untouched", d, 0);

    // R4 threshold compare
    drive(3, 1'b1);
    wr(pa(3), 2); wr(ea(0), 32'h8); wr(ta(0), 2); idle(1);
    chk("R4 prio equal thr", 32'(irq[0]), 0);
    wr(ta(0), 1);
    chk("R4 prio above thr", 32'(irq[0]), 1);
    chk("R4 other ctx", 32'(irq[1]), 0);
    wr(pa(3), 0);  chk("R4 prio zero", 32'(irq[0]), 0);
    wr(pa(3), 7); wr(ta(0), 7); chk("R4 thr seven", 32'(irq[0]), 0);
    wr(ta(0), 0); wr(pa(3), 2);

    // R5 / R6 arbitration and claim
    drive(4, 1'b1); drive(6, 1'b1);
    wr(pa(4), 2); wr(pa(6), 5); wr(ea(0), 32'h58); idle(1);
    rd(ca(0), d); chk("R5 highest prio", d, 6);
    rd(ca(0), d); chk("R5 tie lowest id", d, 3);
    rd(ca(0), d); chk("R6 claimed gone", d, 4);
    rd(ca(0), d); chk("R5 none", d, 0);
    chk("R6 irq drops", 32'(irq[0]), 0);

    // R7 completion needs enable; R8 level re-pend
    wr(ea(0), 32'h50); wr(ca(0), 3); wr(ea(0), 32'h58); idle(2);
    rd(ca(0), d); chk("R7 disabled completion ignored", d, 0);
    wr(ca(1), 3); idle(2);
    rd(ca(0), d); chk("R7 other ctx completion ignored", d, 0);
    wr(ca(0), 3); idle(2);
    rd(ca(0), d); chk("R8 level re-pends", d, 3);
    drive(3, 1'b0); wr(ca(0), 3); idle(2);
    rd(ca(0), d); chk("R8 low input no re-pend", d, 0);
    drive(4, 1'b0); drive(6, 1'b0);
    wr(ca(0), 4); wr(ca(0), 6); idle(2);
    chk("R8 all done", 32'(irq[0]), 0);

    // R9 edge source 20
    wr(pa(20), 4); wr(ea(0), 32'h0010_0000);
    pulse(20); idle(1);
    chk("R9 edge raises", 32'(irq[0]), 1);
    rd(ca(0), d); chk("R9 edge claim", d, 20);
    pulse(20); idle(1);
    rd(ca(0), d); chk("R9 held while busy", d, 0);
    wr(ca(0), 20); idle(1);
    rd(ca(0), d); chk("R9 held edge replayed", d, 20);
    wr(ca(0), 20); idle(1);
    rd(ca(0), d); chk("R9 no stale", d, 0);
    pulse(20); pulse(20); idle(1);
    rd(ca(0), d); chk("R9 merged edges", d, 20);
    wr(ca(0), 20); idle(1);
    rd(ca(0), d); chk("R9 merged once", d, 0);
    wr(ea(0), 0);

    // R3 context independence
    drive(7, 1'b1);
    wr(pa(7), 1); wr(ea(1), 32'h80); idle(1);
    chk("R3 ctx1 irq", 32'(irq[1]), 1);
    chk("R3 ctx0 quiet", 32'(irq[0]), 0);
    rd(ca(0), d); chk("R3 ctx0 claim", d, 0);
    rd(ca(1), d); chk("R3 ctx1 claim", d, 7);
    drive(7, 1'b0); wr(ca(1), 7); idle(2);
    chk("R3 ctx1 done", 32'(irq[1]), 0);
    wr(ea(1), 0);

    // random arbitration rounds over level sources 1..15
    void'($urandom(32'h0005_EED1));
    @(negedge clk); src[15:1] = '1;
    for (int it = 0; it < 24; it++) begin
      for (int j = 1; j < 16; j++) begin
        p[j] = int'($urandom_range(0, 7));
        wr(pa(j), 32'(p[j]));
      end
      mask = $urandom & 32'h0000_FFFE;
      thr  = int'($urandom_range(0, 6));
      wr(ea(0), mask); wr(ta(0), 32'(thr)); idle(2);
      e = best_id(mask, thr);
      rd(pa(1 + it % 15), d); chk("R1 random prio readback", d, 32'(p[1 + it % 15]));
      chk("R4 random irq", 32'(irq[0]), (e != 0) ? 32'd1 : 32'd0);
      rd(ca(0), d); chk("R5 random claim", d, 32'(e));
      if (e != 0) begin wr(ca(0), 32'(e)); idle(2); end
    end

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule